// File: doc/BRIEF.md
# Leading-Edge Pulse Timing Discriminator

This block watches a stream of signed ADC samples, one per clock, and marks the time at which a pulse starts to rise. A lagged differentiator first subtracts the sample taken a programmable number of clocks earlier from the current one. The difference then goes through four identical 1-2-1 binomial smoothing stages. Each stage sums its current input, twice its previous input and its input from two clocks back. The smoothed result is compared against a signed threshold.

A free-running sample counter gives every accepted sample an index, and the first sample after reset has index 0. When the smoothed value moves from at or below the threshold to strictly above it, the block raises a one-cycle strobe. With the strobe it presents the index of the sample that caused the crossing. The detector only re-arms after the smoothed value has dropped back to the threshold or below. Reports are also held back until the delay line and the filter have filled with real samples. The block is meant for front-end timing pickoff on detector channels sampled at around 100 MHz with 12 to 14 bit converters.

Top module: `leading_edge_disc`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `valid_o` is 0 and `time_o` is 0.
- R2: The differentiator output for sample n is x(n) - x(n-L), with samples before reset counted as 0. L is `lag_i`, except that `lag_i` = 0 gives L = 1 and any `lag_i` above MAX_LAG (16) gives L = MAX_LAG.
- R3: The smoothed value is the lagged difference passed four times through y(n) = u(n) + 2u(n-1) + u(n-2), at full precision. It does not wrap for any 14-bit input, including a full-scale step from -8192 to 8191.
- R4: A crossing is detected for sample n when the smoothed value of n is strictly greater than `thr_i` (both signed) and that of sample n-1 is not. A value equal to the threshold never counts as above.
- R5: For a crossing at sample n, `valid_o` is 1 for exactly one cycle, the one that follows the clock edge that captures sample n+5. In that cycle `time_o` equals n modulo 2^TIME_W.
- R6: After a report, no further report occurs until the smoothed value has been at or below the threshold for at least one sample. After that, a new rising crossing is reported again.
- R7: Samples with index below WARM = MAX_LAG + 2*4 = 24 are never reported, and neither is sample 24. A signal that is already above the threshold at the end of warm-up is not reported until it has fallen and risen again.
- R8: Between strobes, `time_o` keeps the last reported value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | SAMPLE_W (14) | Signed ADC sample, one per clock |
| lag_i | input | 5 | Differentiator lag in samples (clamped to 1..MAX_LAG) |
| thr_i | input | FILT_W (23) | Signed threshold on the smoothed value |
| valid_o | output | 1 | One-cycle strobe on a detected leading edge |
| time_o | output | TIME_W (16) | Index of the sample that crossed the threshold |

## Verification
The stimulus includes a single positive step, which fixes the latency and the timestamp offset. A train of positive pulses checks re-arming. Pulses too small to reach the threshold must produce no report. Negative pulses check signed handling, because only their trailing edges may fire. A negative threshold together with the largest lag and with an over-range lag value exposes mistakes in the lag clamp, since the moment of return to above the threshold moves with the lag. A ramp that is already above the threshold during warm-up separates correct arming from firing at the end of warm-up. Thresholds set exactly at and one below the filter peak separate the strict comparison from a non-strict one. A full-scale step exposes any wrap in the filter width.

// File: rtl/led_disc_pkg.sv
package led_disc_pkg;

  // width of the final smoothed value: difference adds 1 bit, each 1-2-1 stage adds 2
  function automatic int filt_w(int sample_w, int stages);
    return sample_w + 1 + 2 * stages;
  endfunction

  // samples needed before the smoothed value depends only on real input
  function automatic int warm_len(int max_lag, int stages);
    return max_lag + 2 * stages;
  endfunction

  // register stages from sample capture to the comparator input
  function automatic int pipe_len(int stages);
    return stages + 1;
  endfunction

endpackage

// File: rtl/led_lag_diff.sv
module led_lag_diff #(
  parameter int IN_W    = 14,
  parameter int MAX_LAG = 16,
  parameter int LAG_W   = 5,
  localparam int OUT_W  = IN_W + 1,
  localparam int IDX_W  = $clog2(MAX_LAG)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic        [LAG_W-1:0] lag_i,
  output logic signed [OUT_W-1:0] d_o
);

  logic signed [IN_W-1:0] hist_q [MAX_LAG];
  logic        [LAG_W-1:0] eff_lag;
  logic        [IDX_W-1:0] tap_sel;

  always_comb begin
    if (lag_i == '0)                     eff_lag = LAG_W'(1);
    else if (lag_i > LAG_W'(MAX_LAG))    eff_lag = LAG_W'(MAX_LAG);
    else                                 eff_lag = lag_i;
    tap_sel = IDX_W'(eff_lag - LAG_W'(1));
  end

  for (genvar t = 0; t < MAX_LAG; t++) begin : g_tap
    if (t == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q[t] <= '0;
        else         hist_q[t] <= x_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q[t] <= '0;
        else         hist_q[t] <= hist_q[t-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_o <= '0;
    else         d_o <= OUT_W'(x_i) - OUT_W'(hist_q[tap_sel]);
  end

endmodule

// File: rtl/led_binom_stage.sv
module led_binom_stage #(
  parameter int IN_W    = 15,
  localparam int OUT_W  = IN_W + 2,
  localparam int SUM_W  = OUT_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  x_i,
  output logic signed [OUT_W-1:0] y_o
);

  logic signed [IN_W-1:0]  x1_q, x2_q;
  logic signed [SUM_W-1:0] sum_w;

  // one guard bit above the output width so a wrap would be visible
  assign sum_w = SUM_W'(x_i) + (SUM_W'(x1_q) <<< 1) + SUM_W'(x2_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0;
      x2_q <= '0;
      y_o  <= '0;
    end else begin
      x1_q <= x_i;
      x2_q <= x1_q;
      y_o  <= $signed(sum_w[OUT_W-1:0]);
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_w[SUM_W-1] == sum_w[SUM_W-2]);

endmodule

// File: rtl/led_edge_timer.sv
module led_edge_timer #(
  parameter int FILT_W = 23,
  parameter int TIME_W = 16,
  parameter int WARM   = 24,
  parameter int PIPE   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [FILT_W-1:0] filt_i,
  input  logic signed [FILT_W-1:0] thr_i,
  output logic                     valid_o,
  output logic        [TIME_W-1:0] time_o
);

  logic [TIME_W-1:0] cnt_q;
  logic              ready_q;
  logic              armed_q;
  logic              above;
  logic              fire;
  logic              ready_hit;

  assign above     = filt_i > thr_i;
  // after this count the comparator sees sample WARM
  assign ready_hit = cnt_q == TIME_W'(WARM + PIPE - 1);
  assign fire      = ready_q & armed_q & above;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      armed_q <= 1'b0;
      valid_o <= 1'b0;
      time_o  <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      ready_q <= ready_q | ready_hit;
      armed_q <= ready_q & ~above;
      valid_o <= fire;
      if (fire) time_o <= cnt_q - TIME_W'(PIPE);
    end
  end

  // R5
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R6
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(armed_q));

  // R7
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> ready_q);

  // R8
  time_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(time_o));

endmodule

// File: rtl/leading_edge_disc.sv
module leading_edge_disc #(
  parameter int SAMPLE_W   = 14,
  parameter int MAX_LAG    = 16,
  parameter int NUM_STAGES = 4,
  parameter int TIME_W     = 16,
  localparam int LAG_W     = $clog2(MAX_LAG + 1),
  localparam int DIFF_W    = SAMPLE_W + 1,
  localparam int FILT_W    = led_disc_pkg::filt_w(SAMPLE_W, NUM_STAGES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [LAG_W-1:0]    lag_i,
  input  logic signed [FILT_W-1:0]   thr_i,
  output logic                       valid_o,
  output logic        [TIME_W-1:0]   time_o
);

  localparam int WARM = led_disc_pkg::warm_len(MAX_LAG, NUM_STAGES);
  localparam int PIPE = led_disc_pkg::pipe_len(NUM_STAGES);

  logic signed [DIFF_W-1:0] diff;
  logic signed [FILT_W-1:0] filt;

  led_lag_diff #(
    .IN_W   (SAMPLE_W),
    .MAX_LAG(MAX_LAG),
    .LAG_W  (LAG_W)
  ) u_diff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .x_i   (sample_i),
    .lag_i (lag_i),
    .d_o   (diff)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    localparam int IW = DIFF_W + 2 * g;
    logic signed [IW+1:0] y;
    if (g == 0) begin : g_first
      led_binom_stage #(.IN_W(IW)) u_stage (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .x_i   (diff),
        .y_o   (y)
      );
    end else begin : g_next
      led_binom_stage #(.IN_W(IW)) u_stage (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .x_i   (g_stage[g-1].y),
        .y_o   (y)
      );
    end
  end

  assign filt = g_stage[NUM_STAGES-1].y;

  led_edge_timer #(
    .FILT_W(FILT_W),
    .TIME_W(TIME_W),
    .WARM  (WARM),
    .PIPE  (PIPE)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .filt_i (filt),
    .thr_i  (thr_i),
    .valid_o(valid_o),
    .time_o (time_o)
  );

endmodule

// File: tb/leading_edge_disc_test.sv
`timescale 1ns/1ps
module leading_edge_disc_test;
  localparam int SW   = 14;
  localparam int ML   = 16;
  localparam int NS   = 4;
  localparam int TW   = 16;
  localparam int FW   = SW + 1 + 2 * NS;
  localparam int WARM = ML + 2 * NS;
  localparam int PIPE = NS + 1;
  localparam int MAXN = 1200;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n = 1'b0;
  logic signed [SW-1:0] sample = '0;
  logic [4:0]           lag = '0;
  logic signed [FW-1:0] thr = '0;
  logic                 valid;
  logic [TW-1:0]        tim;

  leading_edge_disc uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .lag_i(lag),
    .thr_i(thr), .valid_o(valid), .time_o(tim)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int xs [MAXN];
  int yv [NS+1][MAXN];
  bit above_m [MAXN];
  bit fire_m [MAXN];
  int model_fires;
  int peak;

  function automatic int gen(int kind, int n);
    int ph = n % 150;
    case (kind)
      0: return (n < 100) ? 0 : 3000;
      1: return (ph >= 30 && ph < 70) ? 2000 : 0;
      2: return (ph >= 30 && ph < 70) ? 40 : 0;
      3: return (ph >= 30 && ph < 70) ? -3000 : 0;
      4: return (n < 200) ? -8192 : 8191;
      5: return (n < 200) ? n * 20 : ((n < 400) ? 4000 : 7000);
      default: return (n < 120) ? 0 : 1000;
    endcase
  endfunction

  // behavioural model: lagged difference then repeated 1-2-1 smoothing (R2, R3)
  task automatic build(int kind, int lag_v, int len);
    int eff = (lag_v == 0) ? 1 : ((lag_v > ML) ? ML : lag_v);
    peak = -(1 << 30);
    for (int n = 0; n < len; n++) begin
      xs[n] = gen(kind, n);
      yv[0][n] = xs[n] - ((n >= eff) ? xs[n-eff] : 0);
      for (int k = 1; k <= NS; k++)
        yv[k][n] = yv[k-1][n] + 2 * ((n >= 1) ? yv[k-1][n-1] : 0)
                 + ((n >= 2) ? yv[k-1][n-2] : 0);
      if (yv[NS][n] > peak) peak = yv[NS][n];
    end
  endtask

  // first strictly-above sample after a not-above one, outside warm-up (R4, R6, R7)
  task automatic mark(int thr_v, int len);
    model_fires = 0;
    for (int n = 0; n < len; n++) begin
      above_m[n] = yv[NS][n] > thr_v;
      fire_m[n]  = (n >= WARM + 1) && above_m[n] && !above_m[n-1];
      if (fire_m[n] && n + PIPE < len) model_fires++;
    end
  endtask

  task automatic run_case(string name, string req, int kind, int lag_v, int thr_v,
                          bit auto_thr, int thr_off, int len, int min_f, int max_f);
    int last_t = 0;
    int dut_fires = 0;
    bit exp_v;
    build(kind, lag_v, len);
    if (auto_thr) thr_v = peak + thr_off;
    mark(thr_v, len);
    checks++;
    if (model_fires < min_f || model_fires > max_f) begin
      errors++;
      $display("FAIL %s %s stimulus fires: actual %0d expected %0d..%0d",
               name, req, model_fires, min_f, max_f);
    end
    rst_n = 1'b0; lag = 5'(lag_v); thr = FW'(thr_v); sample = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checks++;
    if (valid !== 1'b0 || tim !== '0) begin
      errors++;
      $display("FAIL %s R1 reset: actual valid=%0b time=%0d expected 0/0", name, valid, tim);
    end
    rst_n = 1'b1;
    for (int c = 0; c < len; c++) begin
      sample = SW'(xs[c]);
      @(posedge clk);
      @(negedge clk);
      exp_v = (c >= PIPE) && fire_m[c-PIPE];
      if (exp_v) last_t = c - PIPE;
      if (valid) dut_fires++;
      // R5 strobe timing and index, R8 hold between strobes
      checks++;
      if (valid !== exp_v || tim !== TW'(last_t)) begin
        errors++;
        $display("FAIL %s %s/R5/R8 cycle %0d: actual valid=%0b time=%0d expected valid=%0b time=%0d",
                 name, req, c, valid, tim, exp_v, last_t);
      end
    end
    checks++;
    if (dut_fires != model_fires) begin
      errors++;
      $display("FAIL %s %s report count: actual %0d expected %0d", name, req, dut_fires, model_fires);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R5 run did not end: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R4 single step, R5 latency
    run_case("step",      "R4", 0, 4, 50000, 0, 0, 300, 1, 1);
    // R6 re-arm over a pulse train
    run_case("train",     "R6", 1, 8, 60000, 0, 0, 900, 5, 6);
    // R4 sub-threshold pulses never report
    run_case("small",     "R4", 2, 8, 60000, 0, 0, 600, 0, 0);
    // R3 signed path: only trailing edges of negative pulses rise
    run_case("negative",  "R3", 3, 8, 60000, 0, 0, 900, 5, 6);
    // R2 lag 0 acts as lag 1
    run_case("lag_zero",  "R2", 0, 0, 50000, 0, 0, 300, 1, 1);
    // R2 over-range lag clamps to MAX_LAG; negative threshold exposes lag timing
    run_case("lag_clamp", "R2", 1, 31, -100000, 0, 0, 900, 5, 6);
    run_case("lag_max",   "R2", 1, 16, -100000, 0, 0, 900, 5, 6);
    // R7 above threshold through warm-up: first report only on the later step
    run_case("warm_ramp", "R7", 5, 4, 20000, 0, 0, 600, 1, 1);
    // R4 threshold equal to peak is not a crossing
    run_case("thr_equal", "R4", 6, 4, 0, 1, 0, 300, 0, 0);
    run_case("thr_below", "R4", 6, 4, 0, 1, -1, 300, 1, 1);
    // R3 full-scale step without wrap
    run_case("fullscale", "R3", 4, 16, 4000000, 0, 0, 400, 1, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule